// File: doc/BRIEF.md
# Eight-bit execute stage

This block is the execute step of a small 8-bit pipelined processor. Each cycle it takes an already decoded 4-bit opcode and two 8-bit operands read by the decode step. It also takes a 4-bit signed memory offset, an 8-bit signed branch offset and the address of the instruction that follows the current one.

It computes one 8-bit value. That value is an arithmetic or logic result for register-register operations, or an effective address for loads and stores. It also decides whether a jump or branch is taken and forms the PC-relative branch target. All three results are registered on the rising clock edge, so they appear one cycle after the inputs. The results hold their value while the stall input is high, so a hazard unit upstream can freeze the stage.

Operand A carries the base register for memory operations, the tested register for the branch-if-zero operation, and the destination register's current value for increment. Values are two's complement, and all sums wrap modulo 256.

Top module: `ex_stage8`

## Requirements
- R1: While rst_ni is low, result_o, taken_o and target_o are all zero.
- R2: When stall_i is high at a rising edge, result_o, taken_o and target_o keep their previous values. When stall_i is low, they take the values computed from the inputs at that edge.
- R3: Opcode 0000 gives a_i + b_i, 0001 gives a_i - b_i, and 0010 gives a_i * b_i. Each keeps only the low 8 bits of the result.
- R4: Opcode 0011 gives a_i + 1 modulo 256. Opcode 0110 gives ~a_i, and b_i has no effect on either.
- R5: Opcode 0100 gives a_i & b_i, 0101 gives a_i | b_i, and 0111 gives a_i ^ b_i.
- R6: Opcodes 1000 (load) and 1001 (store) give a_i plus mem_off_i sign-extended from 4 bits, modulo 256. For example, an offset of 4'b1111 subtracts one.
- R7: On every update, target_o = pc_next_i + (br_off_i sign-extended to 8 bits, shifted left by one), modulo 256.
- R8: taken_o is 1 for opcode 1010 (jump). For opcode 1011 (branch-if-zero), taken_o is 1 only when a_i is zero. For every other opcode, taken_o is 0.
- R9: Opcodes 1010, 1011, 1111 (halt) and the unused codes 1100 to 1110 give result_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold all outputs this cycle |
| op_i | input | 4 | Decoded opcode |
| a_i | input | 8 | Operand A (base, tested or incremented register) |
| b_i | input | 8 | Operand B |
| mem_off_i | input | 4 | Signed load/store offset |
| br_off_i | input | 8 | Signed branch offset in instructions |
| pc_next_i | input | 8 | Address of the following instruction |
| result_o | output | 8 | Registered ALU result or effective address |
| taken_o | output | 1 | Registered jump/branch taken flag |
| target_o | output | 8 | Registered branch target address |

## Verification
The bench builds the block with its default widths: 8-bit data, a 4-bit memory offset and an 8-bit branch offset. These are the widths the instruction format fixes. With them, random 8-bit operands cross the wrap points of every sum, difference and product, and random offsets cover both signs. Directed cases add what random draws rarely reach. These are an operand of exactly zero for the branch test, 255 for increment, the extreme offsets, every unused opcode, and stalls placed both back-to-back and in isolation.

// File: rtl/ex_pkg.sv
package ex_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_INC  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_NOT  = 4'h6,
    OP_XOR  = 4'h7,
    OP_LD   = 4'h8,
    OP_ST   = 4'h9,
    OP_JMP  = 4'hA,
    OP_BEQZ = 4'hB,
    OP_HLT  = 4'hF
  } ex_op_e;
endpackage

// File: rtl/ex_alu.sv
module ex_alu import ex_pkg::*; #(
  parameter int DW = 8
) (
  input  ex_op_e        op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  assign prod = PW'(a_i) * PW'(b_i);

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = prod[DW-1:0];
      OP_INC:  res_o = a_i + DW'(1);
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOT:  res_o = ~a_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/ex_addr_unit.sv
module ex_addr_unit #(
  parameter int DW  = 8,
  parameter int MOW = 4,
  parameter int BOW = 8
) (
  input  logic [DW-1:0]  base_i,
  input  logic [MOW-1:0] mem_off_i,
  input  logic [BOW-1:0] br_off_i,
  input  logic [DW-1:0]  pc_next_i,
  output logic [DW-1:0]  ea_o,
  output logic [DW-1:0]  target_o
);
  localparam int MEXT = DW - MOW;
  localparam int BEXT = DW - BOW;

  logic [DW-1:0] mem_off_sx;
  logic [DW-1:0] br_off_sx;

  generate
    if (MEXT > 0) begin : g_msx
      assign mem_off_sx = {{MEXT{mem_off_i[MOW-1]}}, mem_off_i};
    end else begin : g_mnosx
      assign mem_off_sx = mem_off_i[DW-1:0];
    end
    if (BEXT > 0) begin : g_bsx
      assign br_off_sx = {{BEXT{br_off_i[BOW-1]}}, br_off_i};
    end else begin : g_bnosx
      assign br_off_sx = br_off_i[DW-1:0];
    end
  endgenerate

  assign ea_o     = base_i + mem_off_sx;
  // offset counts 2-byte instructions
  assign target_o = pc_next_i + {br_off_sx[DW-2:0], 1'b0};
endmodule

// File: rtl/ex_branch_cond.sv
module ex_branch_cond import ex_pkg::*; #(
  parameter int DW = 8
) (
  input  ex_op_e        op_i,
  input  logic [DW-1:0] a_i,
  output logic          taken_o
);
  always_comb begin
    case (op_i)
      OP_JMP:  taken_o = 1'b1;
      OP_BEQZ: taken_o = (a_i == '0);
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ex_stage8.sv
module ex_stage8 import ex_pkg::*; #(
  parameter int DW  = 8,
  parameter int MOW = 4,
  parameter int BOW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stall_i,
  input  logic [3:0]     op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [MOW-1:0] mem_off_i,
  input  logic [BOW-1:0] br_off_i,
  input  logic [DW-1:0]  pc_next_i,
  output logic [DW-1:0]  result_o,
  output logic           taken_o,
  output logic [DW-1:0]  target_o
);
  ex_op_e        op;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] ea;
  logic [DW-1:0] tgt;
  logic          taken;
  logic [DW-1:0] res_d;

  assign op = ex_op_e'(op_i);

  ex_alu #(.DW(DW)) u_alu (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(alu_res)
  );

  ex_addr_unit #(.DW(DW), .MOW(MOW), .BOW(BOW)) u_addr (
    .base_i   (a_i),
    .mem_off_i(mem_off_i),
    .br_off_i (br_off_i),
    .pc_next_i(pc_next_i),
    .ea_o     (ea),
    .target_o (tgt)
  );

  ex_branch_cond #(.DW(DW)) u_br (
    .op_i   (op),
    .a_i    (a_i),
    .taken_o(taken)
  );

  assign res_d = (op == OP_LD || op == OP_ST) ? ea : alu_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      taken_o  <= 1'b0;
      target_o <= '0;
    end else if (!stall_i) begin
      result_o <= res_d;
      taken_o  <= taken;
      target_o <= tgt;
    end
  end
endmodule

// File: rtl/ex_stage8_chk.sv
module ex_stage8_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] result_o,
  input logic          taken_o,
  input logic [DW-1:0] target_o
);
  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(result_o) && $stable(taken_o) && $stable(target_o)));

  p_inc_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && op_i == 4'h3) |=> (result_o == DW'($past(a_i) + DW'(1))));

  p_jmp_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && op_i == 4'hA) |=> taken_o);

  p_beqz_cond_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && op_i == 4'hB) |=> (taken_o == ($past(a_i) == '0)));

  p_halt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && op_i == 4'hF) |=> (!taken_o && result_o == '0));
endmodule

bind ex_stage8 ex_stage8_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stall_i (stall_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .result_o(result_o),
  .taken_o (taken_o),
  .target_o(target_o)
);

// File: tb/tb_ex_stage8.sv
module tb_ex_stage8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stall_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0, br_off_i = '0, pc_next_i = '0;
  logic [3:0] mem_off_i = '0;
  logic [7:0] result_o, target_o;
  logic       taken_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_res, exp_tgt;
  logic       exp_tk;

  always #2 clk_i = ~clk_i;

  ex_stage8 dut (.*);

  function automatic logic [7:0] m_res(logic [3:0] op, logic [7:0] a, logic [7:0] b,
                                       logic [3:0] mo);
    logic [15:0] p;
    p = 16'(a) * 16'(b);
    case (op)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return p[7:0];
      4'h3: return a + 8'd1;
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return ~a;
      4'h7: return a ^ b;
      4'h8, 4'h9: return a + {{4{mo[3]}}, mo};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_tk(logic [3:0] op, logic [7:0] a);
    return (op == 4'hA) || (op == 4'hB && a == 8'h00);
  endfunction

  function automatic logic [7:0] m_tgt(logic [7:0] pc, logic [7:0] bo);
    return pc + 8'(bo * 2);
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2: return "R3";
      4'h3, 4'h6: return "R4";
      4'h4, 4'h5, 4'h7: return "R5";
      4'h8, 4'h9: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next rising edge
  task automatic step(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [3:0] mo,
                      logic [7:0] bo, logic [7:0] pc, logic st);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; mem_off_i = mo; br_off_i = bo; pc_next_i = pc;
    stall_i = st;
    if (!st) begin
      exp_res = m_res(op, a, b, mo);
      exp_tk  = m_tk(op, a);
      exp_tgt = m_tgt(pc, bo);
    end
    @(posedge clk_i); #1;
    if (st) begin
      chk("R2 result hold", result_o, exp_res);
      chk("R2 taken hold", {7'd0, taken_o}, {7'd0, exp_tk});
      chk("R2 target hold", target_o, exp_tgt);
    end else begin
      chk(tag(op), result_o, exp_res);
      chk("R8 taken", {7'd0, taken_o}, {7'd0, exp_tk});
      chk("R7 target", target_o, exp_tgt);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    op_i = 4'h0; a_i = 8'h5A; b_i = 8'hA5; pc_next_i = 8'h40; br_off_i = 8'h10;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 result", result_o, 8'h00);
    chk("R1 taken", {7'd0, taken_o}, 8'h00);
    chk("R1 target", target_o, 8'h00);
    exp_res = '0; exp_tk = 1'b0; exp_tgt = '0;
    @(negedge clk_i) rst_ni = 1'b1;

    // directed corners
    step(4'h0, 8'hFF, 8'h01, 4'h0, 8'h00, 8'h00, 1'b0); // R3 add wrap
    step(4'h1, 8'h00, 8'h01, 4'h0, 8'h00, 8'h02, 1'b0); // R3 sub borrow
    step(4'h2, 8'h10, 8'h10, 4'h0, 8'h00, 8'h02, 1'b0); // R3 mul low bits
    step(4'h3, 8'hFF, 8'h77, 4'h0, 8'h00, 8'h02, 1'b0); // R4 inc wrap
    step(4'h6, 8'h0F, 8'hCC, 4'h0, 8'h00, 8'h02, 1'b0); // R4 not
    step(4'h8, 8'h00, 8'h00, 4'hF, 8'h00, 8'h02, 1'b0); // R6 -1 wraps to FF
    step(4'h9, 8'hFC, 8'h00, 4'h7, 8'h00, 8'h02, 1'b0); // R6 +7 wraps
    step(4'h9, 8'h80, 8'h00, 4'h8, 8'h00, 8'h02, 1'b0); // R6 -8
    step(4'hA, 8'h33, 8'h00, 4'h0, 8'h80, 8'h02, 1'b0); // R7 most negative
    step(4'hA, 8'h33, 8'h00, 4'h0, 8'h7F, 8'hFE, 1'b0); // R7 wrap
    step(4'hB, 8'h00, 8'h00, 4'h0, 8'hFF, 8'h10, 1'b0); // R8 zero taken
    step(4'hB, 8'h01, 8'h00, 4'h0, 8'hFF, 8'h10, 1'b0); // R8 nonzero not taken
    step(4'hB, 8'h80, 8'h00, 4'h0, 8'h01, 8'h10, 1'b0); // R8 negative not taken
    for (int u = 12; u < 16; u++)
      step(4'(u), 8'h00, 8'hFF, 4'hF, 8'h05, 8'h20, 1'b0); // R9 unused and halt
    step(4'hA, 8'h00, 8'h00, 4'h0, 8'h04, 8'h08, 1'b0);
    step(4'h0, 8'h11, 8'h22, 4'h0, 8'h00, 8'h00, 1'b1); // R2 hold
    step(4'h2, 8'h99, 8'h22, 4'h1, 8'h09, 8'h30, 1'b1); // R2 hold again
    step(4'h0, 8'h11, 8'h22, 4'h0, 8'h00, 8'h00, 1'b0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      step(op, 8'($urandom), 8'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
           ($urandom_range(0, 7) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule